// File: doc/BRIEF.md
# Eight-bit Multicycle Processor Datapath

This block holds every storage element and selector of a small multicycle processor. The processor executes a subset of a 32-bit load/store instruction set on an 8-bit data width. Inside it sit a program counter, an instruction register that is assembled from four byte loads, an eight-entry register file with a constant-zero entry, two operand latches, a memory read latch, an ALU with a registered result, and the selectors that route them.

An external control sequencer drives the per-cycle select and enable inputs and the 3-bit ALU function. It takes back the opcode and funct fields and the zero flag. Memory sits on the other side: it receives an address and write data and returns one byte per cycle. The instruction fields keep their 32-bit positions. Only the low three bits of each 5-bit register field reach the register file, and the immediate and jump fields are cut down to fit eight bits.

Top module: `mc8_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every state element clears to zero: program counter, instruction register, register file, operand latches, memory read latch and ALU result register.
- R2: When `ir_byte_we[k]` is high at an edge, instruction bits [8k+7:8k] take `mem_rdata`. Bytes whose enable is low keep their value. `opcode` shows instruction bits [31:26] and `funct` shows bits [5:0].
- R3: Register 0 always reads as zero. A write addressed to it has no effect.
- R4: The first read index is instruction bits [23:21] and the second is bits [18:16]. The write index is bits [18:16] when `reg_dst` is 0 and bits [13:11] when it is 1. The top two bits of each 5-bit register field are ignored.
- R5: The register write data is the ALU result register when `mem_to_reg` is 0 and the memory read latch when it is 1. The write happens at the edge where `reg_we` is high.
- R6: The two operand latches, the memory read latch and the ALU result register load on every edge. `mem_wdata` is the second operand latch.
- R7: ALU input A is the program counter when `srca_sel` is 0 and the first operand latch when it is 1. Input B is selected by `srcb_sel`: 00 gives the second operand latch, 01 gives the constant 1, 10 gives the immediate (instruction bits [7:0]), and 11 gives the immediate shifted left by two.
- R8: `alu_fn` codes: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). Any other code gives zero. Results wrap modulo 256.
- R9: `zero` is high exactly when the current ALU output is all zeros.
- R10: `mem_addr` is the program counter when `addr_sel` is 0 and the ALU result register when it is 1.
- R11: The program counter changes only at an edge where `pc_en` is high. Its source is chosen by `pc_src`: 00 gives the live ALU output, 01 gives the ALU result register, and 10 gives the jump target {instruction bits [5:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 8 | Byte returned by memory |
| ir_byte_we | input | 4 | Per-byte load enables of the instruction register |
| pc_en | input | 1 | Program counter load enable |
| reg_we | input | 1 | Register file write enable |
| reg_dst | input | 1 | Write index select (0: bits [20:16], 1: bits [15:11]) |
| mem_to_reg | input | 1 | Write data select (0: ALU result register, 1: memory read latch) |
| addr_sel | input | 1 | Address select (0: program counter, 1: ALU result register) |
| srca_sel | input | 1 | ALU input A select |
| srcb_sel | input | 2 | ALU input B select |
| pc_src | input | 2 | Program counter source select |
| alu_fn | input | 3 | ALU function code |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data (second operand latch) |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | ALU output is zero |

## Verification
The embedded properties assume that the sequencer keeps every control input at a defined value on every clock edge. They also assume that any code on `alu_fn` or `pc_src` is legal, unlisted codes included, because the datapath maps each unlisted code to a fixed result.

The bench drives controls only at falling edges. Registers are loaded solely through the block's own paths: a byte from memory is captured into the read latch and then written back into the file. Results are read out only through `mem_wdata` for register contents and through `mem_addr` for the ALU result and the program counter. No value ever depends on internal access.

// File: rtl/mc8_pkg.sv
// Package: shared codes for the eight-bit multicycle datapath.
// Assumes the sequencer uses these same encodings on its control outputs.
package mc8_pkg;
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    localparam logic [1:0] SRCB_REG  = 2'b00;
    localparam logic [1:0] SRCB_ONE  = 2'b01;
    localparam logic [1:0] SRCB_IMM  = 2'b10;
    localparam logic [1:0] SRCB_IMM4 = 2'b11;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_ALUQ = 2'b01;
    localparam logic [1:0] PCS_JUMP = 2'b10;
endpackage

// File: rtl/mc8_instr_reg.sv
// Instruction register built from byte lanes, each with its own load enable.
// Assumes IW is a multiple of eight; lane k holds bits [8k+7:8k].
module mc8_instr_reg #(
    parameter int IW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW/8-1:0] byte_we,
    input  logic [7:0]      din,
    output logic [IW-1:0]   ir
);
    localparam int NB = IW / 8;

    logic [7:0] lane_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        // Lane g: clear on reset, capture memory byte when its enable is high.
        always_ff @(posedge clk) begin
            if (!rst_n)          lane_q[g] <= '0;
            else if (byte_we[g]) lane_q[g] <= din;
        end
        assign ir[g*8 +: 8] = lane_q[g];
    end

    // R2: with no lane enabled the whole word holds.
    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we == '0) |=> $stable(ir));
endmodule

// File: rtl/mc8_regfile.sv
// Register file with two read ports and one write port; entry 0 is constant zero.
// Assumes index width is log2 of the entry count; reads are combinational.
module mc8_regfile #(
    parameter int DW    = 8,
    parameter int NREGS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_a,
    output logic [DW-1:0]            rdata_b
);
    logic [DW-1:0] regs_q [NREGS];

    // Storage: clear all entries on reset, write non-zero indices when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    // R3: the zero entry never leaves zero once reset has run.
    assert_reg0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[0] == '0));
endmodule

// File: rtl/mc8_alu.sv
// Combinational ALU: AND, OR, add, subtract, signed set-less-than.
// Assumes unlisted function codes may appear; they yield zero.
module mc8_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    fn,
    output logic [DW-1:0] y
);
    import mc8_pkg::*;

    // Function decode: one result per code, wraps at DW bits.
    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            default: y = '0;
        endcase
    end

    // R8: compare result is a single-bit truth value.
    always_comb begin
        if (fn == ALU_SLT) begin
            assert_slt_bool_R8: assert (y[DW-1:1] == '0);
        end
    end
endmodule

// File: rtl/mc8_datapath.sv
// Datapath of an eight-bit multicycle processor running 32-bit instructions.
// Assumes an external sequencer supplies all selects and enables every cycle;
// memory returns read data in the same cycle the address is presented.
module mc8_datapath #(
    parameter int DW    = 8,
    parameter int IW    = 32,
    parameter int NREGS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      mem_rdata,
    input  logic [3:0]      ir_byte_we,
    input  logic            pc_en,
    input  logic            reg_we,
    input  logic            reg_dst,
    input  logic            mem_to_reg,
    input  logic            addr_sel,
    input  logic            srca_sel,
    input  logic [1:0]      srcb_sel,
    input  logic [1:0]      pc_src,
    input  logic [2:0]      alu_fn,
    output logic [7:0]      mem_addr,
    output logic [7:0]      mem_wdata,
    output logic [5:0]      opcode,
    output logic [5:0]      funct,
    output logic            zero
);
    import mc8_pkg::*;

    localparam int AW = $clog2(NREGS);

    logic [IW-1:0] ir;
    logic [DW-1:0] pc_q, a_q, b_q, mdr_q, aluout_q;
    logic [DW-1:0] rd_a, rd_b, wr_data;
    logic [DW-1:0] src_a, src_b, alu_y, pc_next, imm, jump_tgt;
    logic [AW-1:0] ra_idx, rb_idx, wr_idx;

    mc8_instr_reg #(.IW(IW)) u_ir (
        .clk(clk), .rst_n(rst_n), .byte_we(ir_byte_we),
        .din(mem_rdata), .ir(ir)
    );

    // Field extraction: only low AW bits of each register field are used.
    assign ra_idx   = ir[21 +: AW];
    assign rb_idx   = ir[16 +: AW];
    assign wr_idx   = reg_dst ? ir[11 +: AW] : ir[16 +: AW];
    assign imm      = ir[DW-1:0];
    assign jump_tgt = {ir[DW-3:0], 2'b00};
    assign wr_data  = mem_to_reg ? mdr_q : aluout_q;

    mc8_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(wr_idx),
        .wdata(wr_data), .raddr_a(ra_idx), .raddr_b(rb_idx),
        .rdata_a(rd_a), .rdata_b(rd_b)
    );

    // Operand selection for the ALU.
    always_comb begin
        src_a = srca_sel ? a_q : pc_q;
        case (srcb_sel)
            SRCB_REG: src_b = b_q;
            SRCB_ONE: src_b = DW'(1);
            SRCB_IMM: src_b = imm;
            default:  src_b = {imm[DW-3:0], 2'b00};
        endcase
    end

    mc8_alu #(.DW(DW)) u_alu (.a(src_a), .b(src_b), .fn(alu_fn), .y(alu_y));

    // Next program counter choice.
    always_comb begin
        case (pc_src)
            PCS_ALUQ: pc_next = aluout_q;
            PCS_JUMP: pc_next = jump_tgt;
            default:  pc_next = alu_y;
        endcase
    end

    // Pipeline latches: operands, read data and ALU result load every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            mdr_q    <= '0;
            aluout_q <= '0;
        end else begin
            a_q      <= rd_a;
            b_q      <= rd_b;
            mdr_q    <= mem_rdata;
            aluout_q <= alu_y;
        end
    end

    // Program counter: loads only on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_en) pc_q <= pc_next;
    end

    assign mem_addr  = addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = ir[IW-1 -: 6];
    assign funct     = ir[5:0];
    assign zero      = (alu_y == '0);

    // R11: without enable the counter holds.
    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> $stable(pc_q));
    // R11: a jump always lands on a word boundary.
    assert_jump_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && pc_src == PCS_JUMP) |=> (pc_q[1:0] == 2'b00));
    // R9: a zero flag is followed by a zero in the result register.
    assert_zero_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (aluout_q == '0));
    // R6: write data is the second read port one cycle later.
    assert_wdata_from_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_wdata == $past(rd_b)));
endmodule

// File: tb/mc8_datapath_tb.sv
module mc8_datapath_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [3:0] ir_byte_we = '0;
    logic       pc_en = 0, reg_we = 0, reg_dst = 0, mem_to_reg = 0;
    logic       addr_sel = 0, srca_sel = 0;
    logic [1:0] srcb_sel = '0, pc_src = '0;
    logic [2:0] alu_fn = '0;
    logic [7:0] mem_addr, mem_wdata;
    logic [5:0] opcode, funct;
    logic       zero;

    int n_chk = 0;
    int n_fail = 0;

    mc8_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .ir_byte_we(ir_byte_we),
        .pc_en(pc_en), .reg_we(reg_we), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .addr_sel(addr_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
        .pc_src(pc_src), .alu_fn(alu_fn), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct), .zero(zero)
    );

    always #4 clk = ~clk;

    // {fn, a, b, expected result}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {3'b000, 8'hF0, 8'h3C, 8'h30},
        {3'b001, 8'hF0, 8'h0C, 8'hFC},
        {3'b010, 8'h7F, 8'h01, 8'h80},
        {3'b010, 8'hFF, 8'h01, 8'h00},
        {3'b110, 8'h10, 8'h10, 8'h00},
        {3'b110, 8'h05, 8'h07, 8'hFE},
        {3'b111, 8'hFE, 8'h03, 8'h01},
        {3'b111, 8'h03, 8'hFE, 8'h00},
        {3'b111, 8'h80, 8'h7F, 8'h01},
        {3'b000, 8'h55, 8'hAA, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ld_byte(input int k, input logic [7:0] v);
        mem_rdata  = v;
        ir_byte_we = 4'(1 << k);
        cyc();
        ir_byte_we = '0;
    endtask

    task automatic set_sel(input logic [4:0] rs, input logic [4:0] rt);
        ld_byte(2, {rs[2:0], rt});
    endtask

    task automatic wr_reg(input logic [4:0] rt, input logic [7:0] v);
        set_sel(5'd0, rt);
        mem_rdata = v;
        cyc();
        reg_dst = 0; mem_to_reg = 1; reg_we = 1;
        cyc();
        reg_we = 0; mem_to_reg = 0;
    endtask

    task automatic rd_reg(input logic [4:0] rt, output logic [7:0] v);
        set_sel(5'd0, rt);
        cyc();
        v = mem_wdata;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        cyc(); cyc();
        rst_n = 1;
        // R1: reset state
        check("R1 pc", 32'(mem_addr), 0);
        check("R1 wdata", 32'(mem_wdata), 0);
        check("R1 opcode", 32'(opcode), 0);
        check("R9 zero after reset", 32'(zero), 1);

        // R8 R9 R10: vector table through ALU
        for (int i = 0; i < NV; i++) begin
            logic [26:0] e;
            e = VEC[i];
            wr_reg(5'd1, e[23:16]);
            wr_reg(5'd2, e[15:8]);
            set_sel(5'd1, 5'd2);
            cyc();
            srca_sel = 1; srcb_sel = 2'b00; alu_fn = e[26:24];
            #1 check("R9 zero flag", 32'(zero), 32'(e[7:0] == 8'h00));
            cyc();
            addr_sel = 1;
            #1 check("R8 R10 alu result", 32'(mem_addr), 32'(e[7:0]));
            addr_sel = 0; srca_sel = 0; alu_fn = 3'b000;
        end

        // R7: immediate operands, R2 funct
        wr_reg(5'd1, 8'h10);
        ld_byte(0, 8'h05);
        set_sel(5'd1, 5'd0);
        cyc();
        check("R2 funct", 32'(funct), 32'h05);
        srca_sel = 1; srcb_sel = 2'b10; alu_fn = 3'b010;
        cyc();
        addr_sel = 1;
        #1 check("R7 imm", 32'(mem_addr), 32'h15);
        srcb_sel = 2'b11;
        cyc();
        check("R7 imm shifted", 32'(mem_addr), 32'h24);
        srca_sel = 0; srcb_sel = 2'b01;
        cyc();
        check("R7 pc plus one", 32'(mem_addr), 32'h01);

        // R5: write from ALU result register (holds 1 while controls held)
        ld_byte(2, {3'd0, 5'd6});
        reg_dst = 0; mem_to_reg = 0; reg_we = 1;
        cyc();
        reg_we = 0;
        addr_sel = 0;
        rd_reg(5'd6, v);
        check("R5 alu write", 32'(v), 32'h01);

        // R11: counting, hold, registered source, jump
        srca_sel = 0; srcb_sel = 2'b01; alu_fn = 3'b010; pc_src = 2'b00; pc_en = 1;
        cyc();
        check("R11 pc inc", 32'(mem_addr), 1);
        cyc();
        check("R11 pc inc2", 32'(mem_addr), 2);
        pc_en = 0;
        cyc();
        check("R11 pc hold", 32'(mem_addr), 2);
        pc_src = 2'b01; pc_en = 1;
        cyc();
        check("R11 pc from alu reg", 32'(mem_addr), 3);
        pc_src = 2'b10;
        cyc();
        check("R11 jump", 32'(mem_addr), 32'h14);
        pc_en = 0; pc_src = 2'b00;

        // R2: opcode byte
        ld_byte(3, 8'hAC);
        check("R2 opcode", 32'(opcode), 32'h2B);

        // R4: destination field select and index truncation
        ld_byte(1, {5'd4, 3'b000});
        set_sel(5'd0, 5'd5);
        mem_rdata = 8'h44;
        cyc();
        reg_dst = 1; mem_to_reg = 1; reg_we = 1;
        cyc();
        reg_we = 0; reg_dst = 0; mem_to_reg = 0;
        rd_reg(5'd4, v);
        check("R4 rd field write", 32'(v), 32'h44);
        rd_reg(5'd5, v);
        check("R4 rt untouched", 32'(v), 32'h00);
        wr_reg(5'b11011, 8'h33);
        rd_reg(5'd3, v);
        check("R4 upper bits ignored", 32'(v), 32'h33);
        check("R6 wdata is B", 32'(mem_wdata), 32'h33);

        // R3: register zero
        wr_reg(5'd0, 8'h5A);
        rd_reg(5'd0, v);
        check("R3 reg0 zero", 32'(v), 32'h00);

        // R1: reset during operation
        rd_reg(5'd3, v);
        rst_n = 0;
        cyc();
        rst_n = 1;
        check("R1 pc cleared", 32'(mem_addr), 0);
        check("R1 wdata cleared", 32'(mem_wdata), 0);
        check("R1 opcode cleared", 32'(opcode), 0);
        check("R1 funct cleared", 32'(funct), 0);
        rd_reg(5'd3, v);
        check("R1 file cleared", 32'(v), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule